// File: doc/BRIEF.md
# Serial-EEPROM-Emulating I2C Slave

This block lets a small on-chip byte memory answer on an I2C bus as a serial EEPROM would. The system clock oversamples SCL and SDA. The block finds start and stop conditions and decodes the slave address byte. It acknowledges when the address is its own and then carries out either a single-byte write or a random or sequential read. SDA is open drain: the block pulls the line low through an output enable and never drives it high.

The memory size decides how the three device-select positions of the address byte are used. At the two smallest sizes all three are compared with the select pins. At the larger sizes the low positions become the top bits of the memory address. A write is only recorded when the data byte is acknowledged. It is committed to the array after the master's stop. For a set time after that, the block is busy: it ignores the bus and acknowledges nothing.

Top module: `i2cee_slave`

## Requirements
- R1: After reset the block does not pull SDA low (`sda_oe_o` = 0) and waits for a start condition.
- R2: An address byte is taken MSB first, as bit 7 first and bit 0 last. Bits 7:4 must equal the `PREFIX` parameter (default 4'b1010), and bit 0 selects the direction (1 = read, 0 = write). A byte that does not match gets no acknowledge, and the block ignores the bus until the next start.
- R3: With `KBITS` of 1 or 2, address bits 3:1 must equal `dev_sel_i[2:0]`.
- R4: With `KBITS` = 4, bit 1 of the address byte is not compared and supplies memory address bit 8. With `KBITS` = 8, bit 1 supplies address bit 8 and bit 2 supplies address bit 9, and only bit 3 is compared with `dev_sel_i[2]`.
- R5: After a matched address byte, an accepted word-address byte or an accepted data byte, the block pulls SDA low for the ninth SCL pulse. It releases SDA after the falling SCL edge that ends that pulse, and it changes `sda_oe_o` only while SCL is low.
- R6: A write transaction is a start, an address byte with R/W = 0, a word-address byte, a data byte, and a stop. It stores the data byte at the selected address.
- R7: The array write starts only after the stop condition. If a start arrives between the data acknowledge and the stop, the pending write is discarded.
- R8: For `BUSY_CYCLES` clock cycles after a write is launched, the block acknowledges nothing and ignores any new transfer, which leaves the memory unchanged.
- R9: A random read is a write header plus word address, then a repeated start and an address byte with R/W = 1. The block then returns the byte at that address, MSB first.
- R10: The block keeps returning bytes while the master acknowledges. The address increments after each byte and wraps at the memory size. After a master NACK the block releases SDA and waits for a start.
- R11: Only one data byte is taken per write. A further data byte in the same transaction gets no acknowledge and does not change the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (the wired value, including this block's own drive) |
| dev_sel_i | input | 3 | Device-select pins compared against address bits 3:1 |
| sda_oe_o | output | 1 | When 1, the block pulls SDA low |

## Verification
The bench places a 2-Kbit instance and an 8-Kbit instance on one wired-AND bus. Their select pins are chosen so that each address byte wakes at most one of them. If the page-bit handling were wrong, the three 8-Kbit locations that differ only in address bits 9:8 would alias, and reading them back would return the same value. A premature commit is caught by aborting a write with a repeated start and reading the location in that same transaction: a design that writes at the data acknowledge would return the new value there. The bench also covers these cases:
- A transfer started right after a stop must get NACKs, and its data must never reach the array.
- A second data byte must not be acknowledged or stored.
- A sequential read that starts at 0xFE must wrap to 0x00.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

    localparam int MAX_AW = 10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Compare prefix and the device-select positions that the size leaves free.
    function automatic logic dev_match(input logic [7:0] b, input logic [3:0] prefix,
                                       input logic [2:0] sel, input int kbits);
        logic ok;
        ok = (b[7:4] == prefix);
        if (kbits <= 2)
            ok = ok && (b[3:1] == sel);
        else if (kbits == 4)
            ok = ok && (b[3:2] == sel[2:1]);
        else
            ok = ok && (b[3] == sel[2]);
        return ok;
    endfunction

    // Upper memory address bits carried in the address byte.
    function automatic logic [1:0] page_bits(input logic [7:0] b, input int kbits);
        logic [1:0] p;
        if (kbits >= 8)
            p = {b[2], b[1]};
        else if (kbits == 4)
            p = {1'b0, b[1]};
        else
            p = 2'b00;
        return p;
    endfunction

endpackage

// File: rtl/i2cee_sync.sv
module i2cee_sync
    import i2cee_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = ~scl_d & scl_s;
        ev_o.scl_fall = scl_d & ~scl_s;
        ev_o.start    = scl_d & scl_s & sda_d & ~sda_s;
        ev_o.stop     = scl_d & scl_s & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2cee_mem.sv
module i2cee_mem #(
    parameter int DEPTH       = 256,
    parameter int AW          = 8,
    parameter int BUSY_CYCLES = 200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    output logic          busy
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [7:0]    cells [DEPTH];
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (wr_en)
            cells[addr] <= wr_data;
        rd_data <= cells[addr];
    end

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (wr_en)
            remain <= CW'(BUSY_CYCLES);
        else if (remain != '0)
            remain <= remain - CW'(1);
    end

    assign busy = (remain != '0);

    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !busy);                                  // R8
    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> busy);                                   // R8

endmodule

// File: rtl/i2cee_ctrl.sv
module i2cee_ctrl
    import i2cee_pkg::*;
#(
    parameter logic [3:0] PREFIX = 4'b1010,
    parameter int         KBITS  = 2,
    parameter int         AW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [2:0]    dev_sel,
    input  logic          busy,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] addr,
    output logic [7:0]    wr_data
);

    phase_e            state;
    logic [7:0]        shreg;
    logic [2:0]        bitcnt;
    logic              byte_done;
    logic              rw;
    logic              mack;
    logic              wr_pend;
    logic              launch;
    logic [MAX_AW-1:0] lin;
    logic [7:0]        wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            byte_done <= 1'b0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            wr_pend   <= 1'b0;
            launch    <= 1'b0;
            lin       <= '0;
            wdata     <= '0;
            sda_oe    <= 1'b0;
        end else begin
            launch <= 1'b0;
            if (ev.stop) begin
                state     <= ST_IDLE;
                sda_oe    <= 1'b0;
                byte_done <= 1'b0;
                launch    <= wr_pend;
                wr_pend   <= 1'b0;
            end else if (ev.start) begin
                sda_oe    <= 1'b0;
                wr_pend   <= 1'b0;
                bitcnt    <= '0;
                byte_done <= 1'b0;
                state     <= (busy || launch) ? ST_IDLE : ST_DEV;
            end else begin
                case (state)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (ev.scl_rise) begin
                            shreg     <= {shreg[6:0], ev.sda};
                            bitcnt    <= bitcnt + 3'd1;
                            byte_done <= (bitcnt == 3'd7);
                        end else if (ev.scl_fall && byte_done) begin
                            byte_done <= 1'b0;
                            case (state)
                                ST_DEV: begin
                                    if (dev_match(shreg, PREFIX, dev_sel, KBITS)) begin
                                        sda_oe    <= 1'b1;
                                        rw        <= shreg[0];
                                        lin[9:8]  <= page_bits(shreg, KBITS);
                                        state     <= ST_DEV_ACK;
                                    end else begin
                                        state     <= ST_IDLE;
                                    end
                                end
                                ST_WADDR: begin
                                    sda_oe   <= 1'b1;
                                    lin[7:0] <= shreg;
                                    state    <= ST_WADDR_ACK;
                                end
                                default: begin
                                    sda_oe   <= 1'b1;
                                    wdata    <= shreg;
                                    wr_pend  <= 1'b1;
                                    state    <= ST_WDATA_ACK;
                                end
                            endcase
                        end
                    end
                    ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            case (state)
                                ST_DEV_ACK: begin
                                    if (rw) begin
                                        state  <= ST_RDATA;
                                        sda_oe <= ~rd_data[7];
                                    end else begin
                                        state  <= ST_WADDR;
                                    end
                                end
                                ST_WADDR_ACK: state <= ST_WDATA;
                                default:      state <= ST_IDLE;
                            endcase
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_rise) begin
                            bitcnt    <= bitcnt + 3'd1;
                            byte_done <= (bitcnt == 3'd7);
                        end else if (ev.scl_fall) begin
                            if (byte_done) begin
                                byte_done <= 1'b0;
                                sda_oe    <= 1'b0;
                                lin       <= lin + MAX_AW'(1);
                                state     <= ST_RD_ACK;
                            end else begin
                                sda_oe    <= ~rd_data[3'd7 - bitcnt];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                state  <= ST_RDATA;
                                bitcnt <= '0;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_en   = launch;
    assign addr    = lin[AW-1:0];
    assign wr_data = wdata;

    AST_OE_MOVES_WITH_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !ev.scl);                     // R5
    AST_LAUNCH_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        launch |-> $past(ev.stop));                        // R7
    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !busy);                          // R8
    AST_START_CLEARS_PENDING: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !launch);                             // R7

endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
    import i2cee_pkg::*;
#(
    parameter int         KBITS       = 2,
    parameter logic [3:0] PREFIX      = 4'b1010,
    parameter int         BUSY_CYCLES = 200,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel_i,
    output logic       sda_oe_o
);

    localparam int DEPTH = KBITS * 128;
    localparam int AW    = $clog2(DEPTH);

    bus_ev_t       ev;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;
    logic          busy;

    i2cee_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2cee_ctrl #(.PREFIX(PREFIX), .KBITS(KBITS), .AW(AW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .dev_sel (dev_sel_i),
        .busy    (busy),
        .rd_data (rd_data),
        .sda_oe  (sda_oe_o),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data)
    );

    i2cee_mem #(.DEPTH(DEPTH), .AW(AW), .BUSY_CYCLES(BUSY_CYCLES)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .busy    (busy)
    );

endmodule

// File: tb/i2cee_slave_tb_top.sv
`timescale 1ns/1ps
module i2cee_slave_tb_top;

    localparam int BUSY = 400;
    localparam int Q    = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic oe_a, oe_b;
    logic sda_bus;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    logic [7:0] mir2 [256];
    bit         kn2  [256];
    logic [7:0] mir8 [1024];
    bit         kn8  [1024];

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~oe_a & ~oe_b;

    i2cee_slave #(.KBITS(2), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
        .dev_sel_i(3'b011), .sda_oe_o(oe_a));

    i2cee_slave #(.KBITS(8), .BUSY_CYCLES(BUSY)) dut_b (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
        .dev_sel_i(3'b100), .sda_oe_o(oe_b));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic m_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic v);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        v = sda_bus; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(v);
        ack = ~v;
    endtask

    task automatic rx_byte(input logic give_ack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(v);
            b[i] = v;
        end
        send_bit(~give_ack);
    endtask

    // Bench model of the address byte expected for each instance (R2, R4).
    function automatic logic [6:0] dev7(input int which, input int a);
        logic [9:0] av;
        av = 10'(a);
        return (which == 0) ? 7'b1010_011 : {4'b1010, 1'b1, av[9:8]};
    endfunction

    // Expected acknowledge for a write header on the shared bus (R2, R3, R4).
    function automatic logic exp_ack(input logic [3:0] pre, input logic [2:0] s);
        return (pre == 4'b1010) && ((s == 3'b011) || s[2]);
    endfunction

    function automatic int msize(input int which);
        return (which == 0) ? 256 : 1024;
    endfunction

    task automatic do_write(input int which, input int a, input logic [7:0] d,
                            output logic k1, output logic k2, output logic k3);
        logic [7:0] w;
        w = 8'(a);
        m_start();
        tx_byte({dev7(which, a), 1'b0}, k1);
        tx_byte(w, k2);
        tx_byte(d, k3);
        m_stop();
        if (k1 && k2 && k3) begin
            if (which == 0) begin mir2[a] = d; kn2[a] = 1'b1; end
            else begin mir8[a] = d; kn8[a] = 1'b1; end
        end
        repeat (BUSY + 50) @(posedge clk);
        #1;
    endtask

    task automatic do_read(input int which, input int a, input int n,
                           output logic [7:0] r0, output logic [7:0] r1,
                           output logic [7:0] r2, output logic allk);
        logic k1, k2, k3;
        logic [7:0] w;
        logic [7:0] t;
        w = 8'(a);
        r0 = '0; r1 = '0; r2 = '0;
        m_start();
        tx_byte({dev7(which, a), 1'b0}, k1);
        tx_byte(w, k2);
        m_start();
        tx_byte({dev7(which, a), 1'b1}, k3);
        for (int i = 0; i < n; i++) begin
            rx_byte(i < n - 1, t);
            if (i == 0) r0 = t;
            else if (i == 1) r1 = t;
            else r2 = t;
        end
        m_stop();
        allk = k1 & k2 & k3;
        wq();
    endtask

    task automatic wr_chk(input int which, input int a, input logic [7:0] d, input string req);
        logic k1, k2, k3;
        do_write(which, a, d, k1, k2, k3);
        chk(req, "write acks", {29'd0, k1, k2, k3}, 7);
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 200000; wd++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic k1, k2, k3, allk;
        logic [7:0] r0, r1, r2;
        void'($urandom(32'h5eed));
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;

        // R1: idle after reset
        chk("R1", "oe 2K after reset", {31'd0, oe_a}, 0);
        chk("R1", "oe 8K after reset", {31'd0, oe_b}, 0);

        // R5 R6 R9: basic write then random read
        wr_chk(0, 8'h10, 8'hA5, "R6");
        do_read(0, 8'h10, 1, r0, r1, r2, allk);
        chk("R9", "read acks", {31'd0, allk}, 1);
        chk("R9", "read 0x10", {24'd0, r0}, 8'hA5);

        // R2: wrong prefix gets no acknowledge
        m_start();
        tx_byte({4'b1011, 3'b011, 1'b0}, k1);
        m_stop();
        chk("R2", "prefix 1011 ack", {31'd0, k1}, 0);

        // R3: select bit 0 mismatch on the 2K part (the 8K part has A2=1, also no match)
        m_start();
        tx_byte({4'b1010, 3'b010, 1'b0}, k1);
        m_stop();
        chk("R3", "sel 010 ack", {31'd0, k1}, 0);
        m_start();
        tx_byte({4'b1010, 3'b001, 1'b0}, k1);
        m_stop();
        chk("R3", "sel 001 ack", {31'd0, k1}, 0);

        // R4: on the 8K part bits 2:1 are address bits 9:8
        wr_chk(1, 10'h055, 8'h11, "R4");
        wr_chk(1, 10'h155, 8'h3C, "R4");
        wr_chk(1, 10'h255, 8'hC3, "R4");
        do_read(1, 10'h155, 1, r0, r1, r2, allk);
        chk("R4", "8K read 0x155", {24'd0, r0}, 8'h3C);
        do_read(1, 10'h255, 1, r0, r1, r2, allk);
        chk("R4", "8K read 0x255", {24'd0, r0}, 8'hC3);
        do_read(1, 10'h055, 1, r0, r1, r2, allk);
        chk("R4", "8K read 0x055", {24'd0, r0}, 8'h11);

        // R7: start before stop discards the pending write
        wr_chk(0, 8'h20, 8'h5A, "R7");
        m_start();
        tx_byte({7'b1010_011, 1'b0}, k1);
        tx_byte(8'h20, k2);
        tx_byte(8'h77, k3);
        chk("R5", "data ack before abort", {31'd0, k3}, 1);
        m_start();
        tx_byte({7'b1010_011, 1'b0}, k1);
        tx_byte(8'h20, k2);
        m_start();
        tx_byte({7'b1010_011, 1'b1}, k3);
        rx_byte(1'b0, r0);
        m_stop();
        chk("R7", "header ack right after abort", {31'd0, k1}, 1);
        chk("R7", "location after abort", {24'd0, r0}, 8'h5A);
        wq();

        // R8: transfer during busy is ignored
        wr_chk(0, 8'h40, 8'h12, "R8");
        wr_chk(0, 8'h41, 8'h34, "R8");
        m_start();
        tx_byte({7'b1010_011, 1'b0}, k1);
        tx_byte(8'h41, k2);
        tx_byte(8'hEE, k3);
        m_stop();
        repeat (20) @(posedge clk);
        #1;
        m_start();
        tx_byte({7'b1010_011, 1'b0}, k1);
        chk("R8", "ack during busy", {31'd0, k1}, 0);
        tx_byte(8'h40, k2);
        tx_byte(8'hDD, k3);
        m_stop();
        repeat (BUSY + 50) @(posedge clk);
        #1;
        do_read(0, 8'h40, 2, r0, r1, r2, allk);
        chk("R8", "ack after busy ends", {31'd0, allk}, 1);
        chk("R8", "0x40 untouched", {24'd0, r0}, 8'h12);
        chk("R6", "0x41 written before busy", {24'd0, r1}, 8'hEE);
        mir2[8'h41] = 8'hEE;

        // R10: sequential read wraps, then the slave releases after NACK
        wr_chk(0, 8'hFE, 8'h01, "R10");
        wr_chk(0, 8'hFF, 8'h02, "R10");
        wr_chk(0, 8'h00, 8'h03, "R10");
        m_start();
        tx_byte({7'b1010_011, 1'b0}, k1);
        tx_byte(8'hFE, k2);
        m_start();
        tx_byte({7'b1010_011, 1'b1}, k3);
        rx_byte(1'b1, r0);
        rx_byte(1'b1, r1);
        rx_byte(1'b0, r2);
        wq();
        chk("R10", "released after NACK", {31'd0, sda_bus}, 1);
        m_stop();
        chk("R10", "seq byte 0", {24'd0, r0}, 8'h01);
        chk("R10", "seq byte 1", {24'd0, r1}, 8'h02);
        chk("R10", "seq byte 2 wrapped", {24'd0, r2}, 8'h03);

        // R11: second data byte not taken
        wr_chk(0, 8'h31, 8'h99, "R11");
        m_start();
        tx_byte({7'b1010_011, 1'b0}, k1);
        tx_byte(8'h30, k2);
        tx_byte(8'h44, k3);
        tx_byte(8'h55, k1);
        m_stop();
        repeat (BUSY + 50) @(posedge clk);
        #1;
        chk("R11", "extra byte ack", {31'd0, k1}, 0);
        mir2[8'h30] = 8'h44; kn2[8'h30] = 1'b1;
        do_read(0, 8'h30, 2, r0, r1, r2, allk);
        chk("R11", "0x30 holds first byte", {24'd0, r0}, 8'h44);
        chk("R11", "0x31 unchanged", {24'd0, r1}, 8'h99);

        // Random mix
        for (int it = 0; it < 16; it++) begin
            int which;
            int a;
            int nx;
            logic [7:0] d;
            logic [3:0] pre;
            logic [2:0] s;
            which = int'($urandom_range(0, 1));
            a = int'($urandom_range(0, msize(which) - 1));
            d = 8'($urandom);
            wr_chk(which, a, d, "R6");
            do_read(which, a, 2, r0, r1, r2, allk);
            chk("R9", "random readback", {24'd0, r0}, {24'd0, d});
            nx = (a + 1) % msize(which);
            if (which == 0 && kn2[nx]) chk("R10", "random next 2K", {24'd0, r1}, {24'd0, mir2[nx]});
            if (which == 1 && kn8[nx]) chk("R10", "random next 8K", {24'd0, r1}, {24'd0, mir8[nx]});
            pre = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b1010;
            s = 3'($urandom);
            m_start();
            tx_byte({pre, s, 1'b0}, k1);
            m_stop();
            chk("R2", "random address probe", {31'd0, k1}, {31'd0, exp_ack(pre, s)});
            wq();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule